// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This unit works beside a small CPU sequencer. It turns either a two-byte software interrupt instruction or an internal fault into the address of a handler. When a request is accepted, the unit latches the current code segment, the current offset and the stack pointer. It then makes two 16-bit stack writes that save the return point. After that it makes two 16-bit reads that fetch the segment:offset pair held in the vector table, and it presents the new segment and offset together with a one-cycle completion pulse.

The vector table has 256 entries of four bytes each. The table can sit at address zero (legacy mode) or at a base held in a loadable register (extended mode). The return offset depends on what started the dispatch. A fault saves the offset of the instruction that failed, so that instruction can be retried. A software interrupt saves the offset just past its two bytes.

Top module: `irq_vector_dispatch`

## Requirements
- R1: A request on the instruction side is accepted only when `sw_valid` is high and `sw_op` equals 0xCD. The vector taken is then `sw_vec`. Any other opcode value is ignored: busy stays low and no write or read is issued.
- R2: The entry address is the table base plus four times the vector, taken modulo 2^AW. The offset word is read at the entry address and the segment word at entry+2.
- R3: With `ext_mode`=0 the table base is 0. With `ext_mode`=1 the base is the value last loaded through `tbase_we`/`tbase_wd`.
- R4: The fault request bits map to vectors as follows: bit 0 (divide by zero) to vector 0, bit 1 (invalid opcode) to vector 6, bit 2 (alignment check) to vector 17. When several bits are set, the lowest vector is taken.
- R5: When a fault and a valid software interrupt arrive in the same cycle, the fault is taken.
- R6: The saved return offset is `cur_off` for a fault and `cur_off`+2 (modulo 2^16) for a software interrupt.
- R7: The first write goes to `sp_in`-2 and carries `cur_seg`. The next cycle's write goes to `sp_in`-4 and carries the return offset. At completion `sp_out` equals `sp_in`-4.
- R8: Both reads follow both writes. Each read is a one-cycle `rd_en` pulse, and the second read is issued only after `rd_valid` has returned the first word. Reads and writes never overlap.
- R9: `done` pulses for one cycle after the second `rd_valid`. At that point `taken_vec`, `hnd_off` and `hnd_seg` hold the results, and they stay unchanged until the next acceptance.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle, and falls in the cycle that follows. Requests that arrive while busy are ignored.
- R11: A synchronous active-high reset clears the table-base register to 0 and returns the unit to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 selects the loadable table base; 0 selects base 0 |
| tbase_we | input | 1 | Load strobe for the table-base register |
| tbase_wd | input | AW | Value loaded into the table-base register |
| sw_valid | input | 1 | Instruction bytes are presented |
| sw_op | input | 8 | First instruction byte (opcode) |
| sw_vec | input | 8 | Second instruction byte (vector number) |
| fault_req | input | 3 | Fault requests: bit0 divide, bit1 invalid opcode, bit2 alignment |
| cur_seg | input | 16 | Segment of the current instruction |
| cur_off | input | 16 | Offset of the current instruction |
| sp_in | input | AW | Stack pointer at acceptance |
| rd_en | output | 1 | Read request pulse |
| rd_addr | output | AW | Read address |
| rd_valid | input | 1 | Read data is returned |
| rd_data | input | 16 | Read data word |
| wr_en | output | 1 | Stack write strobe |
| wr_addr | output | AW | Stack write address |
| wr_data | output | 16 | Stack write data |
| busy | output | 1 | Dispatch in progress |
| done | output | 1 | One-cycle completion pulse |
| hnd_seg | output | 16 | Handler segment |
| hnd_off | output | 16 | Handler offset |
| sp_out | output | AW | Stack pointer after both pushes |
| taken_vec | output | 8 | Vector number that was dispatched |

## Verification
A fault request and a software interrupt instruction can arrive in the same cycle, and both compete for the same acceptance slot. The bench provokes this in directed cases and in random cycles that set fault bits and a valid 0xCD opcode together. It judges the outcome by the vector dispatched, by the table address read and by the saved return offset, which must be the unadvanced `cur_off`. A second collision is also covered: requests that arrive while a dispatch is running must leave the write count and the latched results unchanged.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam logic [7:0] SWI_OPCODE = 8'hCD;
    localparam int         WORD_W     = 16;
    localparam int         VEC_W      = 8;
    localparam int         N_FAULT    = 3;

    // Fault index to vector; ascending so a lower index means higher priority
    localparam logic [VEC_W-1:0] FAULT_VEC [N_FAULT] = '{8'd0, 8'd6, 8'd17};

    typedef struct packed {
        logic             valid;
        logic             is_fault;
        logic [VEC_W-1:0] vec;
    } disp_req_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_SEG,
        ST_PUSH_OFF,
        ST_RQ_OFF,
        ST_WT_OFF,
        ST_RQ_SEG,
        ST_WT_SEG,
        ST_DONE
    } disp_state_t;

    function automatic logic [WORD_W-1:0] ret_offset(input logic [WORD_W-1:0] off,
                                                     input logic is_fault);
        return is_fault ? off : off + WORD_W'(2);
    endfunction

endpackage

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
    import irqd_pkg::*;
(
    input  logic               sw_valid,
    input  logic [7:0]         sw_op,
    input  logic [VEC_W-1:0]   sw_vec,
    input  logic [N_FAULT-1:0] fault_req,
    output disp_req_t          req
);
    always_comb begin
        req = '0;
        if (sw_valid && sw_op == SWI_OPCODE) begin
            req.valid = 1'b1;
            req.vec   = sw_vec;
        end
        // scan downward so the lowest-index fault is applied last and wins
        for (int i = N_FAULT - 1; i >= 0; i--) begin
            if (fault_req[i]) begin
                req.valid    = 1'b1;
                req.is_fault = 1'b1;
                req.vec      = FAULT_VEC[i];
            end
        end
    end
endmodule

// File: rtl/irqd_base.sv
module irqd_base #(
    parameter int AW           = 16,
    parameter bit HAS_BASE_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_mode,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] base
);
    generate
        if (HAS_BASE_REG) begin : g_reg
            logic [AW-1:0] base_q;
            always_ff @(posedge clk) begin
                if (rst)       base_q <= '0;
                else if (load) base_q <= load_val;
            end
            assign base = ext_mode ? base_q : '0;
        end else begin : g_fixed
            logic unused_ok;
            assign unused_ok = ^{clk, rst, ext_mode, load, load_val};
            assign base      = '0;
        end
    endgenerate
endmodule

// File: rtl/irqd_seq.sv
module irqd_seq
    import irqd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  disp_req_t         req,
    input  logic [AW-1:0]     base,
    input  logic [WORD_W-1:0] cur_seg,
    input  logic [WORD_W-1:0] cur_off,
    input  logic [AW-1:0]     sp_in,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] hnd_seg,
    output logic [WORD_W-1:0] hnd_off,
    output logic [AW-1:0]     sp_out,
    output logic [VEC_W-1:0]  taken_vec
);
    localparam logic [AW-1:0] STEP = AW'(2);

    disp_state_t       st_q;
    logic [AW-1:0]     ent_q, sp_q;
    logic [WORD_W-1:0] seg_q, ret_q, hseg_q, hoff_q;
    logic [VEC_W-1:0]  vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ent_q  <= '0;
            sp_q   <= '0;
            seg_q  <= '0;
            ret_q  <= '0;
            hseg_q <= '0;
            hoff_q <= '0;
            vec_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req.valid) begin
                    vec_q <= req.vec;
                    ent_q <= base + AW'({req.vec, 2'b00});
                    sp_q  <= sp_in;
                    seg_q <= cur_seg;
                    ret_q <= ret_offset(cur_off, req.is_fault);
                    st_q  <= ST_PUSH_SEG;
                end
                ST_PUSH_SEG: begin
                    sp_q <= sp_q - STEP;
                    st_q <= ST_PUSH_OFF;
                end
                ST_PUSH_OFF: begin
                    sp_q <= sp_q - STEP;
                    st_q <= ST_RQ_OFF;
                end
                ST_RQ_OFF: st_q <= ST_WT_OFF;
                ST_WT_OFF: if (rd_valid) begin
                    hoff_q <= rd_data;
                    st_q   <= ST_RQ_SEG;
                end
                ST_RQ_SEG: st_q <= ST_WT_SEG;
                ST_WT_SEG: if (rd_valid) begin
                    hseg_q <= rd_data;
                    st_q   <= ST_DONE;
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en   = (st_q == ST_PUSH_SEG) || (st_q == ST_PUSH_OFF);
        wr_addr = sp_q - STEP;
        wr_data = (st_q == ST_PUSH_SEG) ? seg_q : ret_q;
        rd_en   = (st_q == ST_RQ_OFF) || (st_q == ST_RQ_SEG);
        rd_addr = (st_q == ST_RQ_SEG) ? ent_q + STEP : ent_q;
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = (st_q == ST_DONE);
    assign hnd_seg   = hseg_q;
    assign hnd_off   = hoff_q;
    assign sp_out    = sp_q;
    assign taken_vec = vec_q;
endmodule

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch
    import irqd_pkg::*;
#(
    parameter int AW           = 16,
    parameter bit HAS_BASE_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_mode,
    input  logic               tbase_we,
    input  logic [AW-1:0]      tbase_wd,
    input  logic               sw_valid,
    input  logic [7:0]         sw_op,
    input  logic [7:0]         sw_vec,
    input  logic [2:0]         fault_req,
    input  logic [15:0]        cur_seg,
    input  logic [15:0]        cur_off,
    input  logic [AW-1:0]      sp_in,
    output logic               rd_en,
    output logic [AW-1:0]      rd_addr,
    input  logic               rd_valid,
    input  logic [15:0]        rd_data,
    output logic               wr_en,
    output logic [AW-1:0]      wr_addr,
    output logic [15:0]        wr_data,
    output logic               busy,
    output logic               done,
    output logic [15:0]        hnd_seg,
    output logic [15:0]        hnd_off,
    output logic [AW-1:0]      sp_out,
    output logic [7:0]         taken_vec
);
    disp_req_t     req;
    logic [AW-1:0] base;

    irqd_arbiter u_arb (
        .sw_valid  (sw_valid),
        .sw_op     (sw_op),
        .sw_vec    (sw_vec),
        .fault_req (fault_req),
        .req       (req)
    );

    irqd_base #(.AW(AW), .HAS_BASE_REG(HAS_BASE_REG)) u_base (
        .clk      (clk),
        .rst      (rst),
        .ext_mode (ext_mode),
        .load     (tbase_we),
        .load_val (tbase_wd),
        .base     (base)
    );

    irqd_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .base      (base),
        .cur_seg   (cur_seg),
        .cur_off   (cur_off),
        .sp_in     (sp_in),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .done      (done),
        .hnd_seg   (hnd_seg),
        .hnd_off   (hnd_off),
        .sp_out    (sp_out),
        .taken_vec (taken_vec)
    );
endmodule

// File: rtl/irq_vector_dispatch_chk.sv
module irq_vector_dispatch_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] sp_in,
    input logic          rd_en,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          busy,
    input logic          done
);
    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_idle_after_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));

    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!wr_en && !rd_en));

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en));

    p_read_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> busy);

    p_first_push_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (wr_en && wr_addr == $past(sp_in) - AW'(2)));

    p_second_push_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> (wr_en && wr_addr == $past(wr_addr) - AW'(2)));
endmodule

bind irq_vector_dispatch irq_vector_dispatch_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sp_in   (sp_in),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .busy    (busy),
    .done    (done)
);

// File: tb/test_irq_vector_dispatch.sv
`timescale 1ns/1ps
module test_irq_vector_dispatch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_mode = 1'b0, tbase_we = 1'b0;
    logic [15:0] tbase_wd = '0;
    logic        sw_valid = 1'b0;
    logic [7:0]  sw_op = '0, sw_vec = '0;
    logic [2:0]  fault_req = '0;
    logic [15:0] cur_seg = '0, cur_off = '0, sp_in = '0;
    logic        rd_en, rd_valid = 1'b0;
    logic [15:0] rd_addr, rd_data = '0;
    logic        wr_en, busy, done;
    logic [15:0] wr_addr, wr_data, hnd_seg, hnd_off, sp_out;
    logic [7:0]  taken_vec;

    int checks = 0, errors = 0;
    int nw = 0, nr = 0, cyc = 0;
    logic [15:0] wa [4], wd [4], ra [4];
    int wcyc [4], rcyc [4];
    logic [15:0] model_base = '0;
    int rd_cnt = 0;
    logic [15:0] rd_lat_addr = '0;

    always #2 clk = ~clk;

    irq_vector_dispatch i_irq_vector_dispatch (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .tbase_we(tbase_we), .tbase_wd(tbase_wd),
        .sw_valid(sw_valid), .sw_op(sw_op), .sw_vec(sw_vec), .fault_req(fault_req),
        .cur_seg(cur_seg), .cur_off(cur_off), .sp_in(sp_in),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .hnd_seg(hnd_seg), .hnd_off(hnd_off),
        .sp_out(sp_out), .taken_vec(taken_vec)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return (a * 16'h03B1) ^ 16'h5AC7;
    endfunction

    function automatic int fault_vector(input logic [2:0] f);
        if (f[0]) return 0;
        if (f[1]) return 6;
        if (f[2]) return 17;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // bus monitor and memory responder, both away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (wr_en) begin
            if (nw < 4) begin wa[nw] = wr_addr; wd[nw] = wr_data; wcyc[nw] = cyc; end
            nw++;
        end
        if (rd_en) begin
            if (nr < 4) begin ra[nr] = rd_addr; rcyc[nr] = cyc; end
            nr++;
        end
        rd_valid = 1'b0;
        if (rd_cnt != 0) begin
            rd_cnt--;
            if (rd_cnt == 0) begin
                rd_valid = 1'b1;
                rd_data  = mem_word(rd_lat_addr);
            end
        end
        if (rd_en) begin
            rd_lat_addr = rd_addr;
            rd_cnt      = 1 + int'($urandom % 3);
        end
    end

    task automatic load_base(input logic [15:0] v);
        @(negedge clk);
        tbase_we = 1'b1; tbase_wd = v;
        @(negedge clk);
        tbase_we = 1'b0;
        model_base = v;
    endtask

    task automatic run_case(input bit ext, input logic [2:0] fb, input bit sv,
                            input logic [7:0] op, input logic [7:0] vec,
                            input logic [15:0] seg, input logic [15:0] off,
                            input logic [15:0] sp, input bit poke);
        int exp_vec;
        logic [15:0] exp_ret, ent;
        int cycles;
        exp_vec = fault_vector(fb);
        exp_ret = off;
        if (exp_vec < 0 && sv && op == 8'hCD) begin
            exp_vec = int'(vec);
            exp_ret = off + 16'd2;
        end
        @(negedge clk);
        nw = 0; nr = 0;
        ext_mode = ext; fault_req = fb; sw_valid = sv; sw_op = op; sw_vec = vec;
        cur_seg = seg; cur_off = off; sp_in = sp;
        @(negedge clk);
        sw_valid = 1'b0; fault_req = '0;
        if (exp_vec < 0) begin
            repeat (4) @(negedge clk);
            check(busy == 1'b0 && nw == 0 && nr == 0, "R1", "non-0xCD opcode ignored",
                  nw + nr + int'(busy), 0);
            return;
        end
        cycles = 0;
        while (!done && cycles < 200) begin
            if (poke && cycles == 2) begin
                sw_valid = 1'b1; sw_op = 8'hCD; sw_vec = vec ^ 8'h55; fault_req = 3'b001;
            end else begin
                sw_valid = 1'b0; fault_req = '0;
            end
            @(negedge clk);
            cycles++;
        end
        sw_valid = 1'b0; fault_req = '0;
        if (!done) begin
            check(1'b0, "R9", "watchdog: done never seen", 0, 1);
            return;
        end
        ent = (ext ? model_base : 16'h0) + 16'(exp_vec * 4);
        check(taken_vec == 8'(exp_vec), fb != 0 ? "R4/R5" : "R1", "vector taken",
              int'(taken_vec), exp_vec);
        check(ra[0] == ent && ra[1] == ent + 16'd2 && nr == 2, "R2", "entry read addresses",
              int'(ra[0]), int'(ent));
        check(wa[0] == sp - 16'd2 && wd[0] == seg, "R7", "segment push",
              int'(wd[0]), int'(seg));
        check(wa[1] == sp - 16'd4 && wd[1] == exp_ret && nw == 2, "R6", "return offset push",
              int'(wd[1]), int'(exp_ret));
        check(wcyc[1] < rcyc[0] && rcyc[0] < rcyc[1], "R8", "read ordering after pushes",
              rcyc[0], wcyc[1] + 1);
        check(hnd_off == mem_word(ent) && hnd_seg == mem_word(ent + 16'd2), "R9",
              "handler offset", int'(hnd_off), int'(mem_word(ent)));
        check(sp_out == sp - 16'd4, "R7", "final stack pointer", int'(sp_out), int'(sp - 16'd4));
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R10", "busy released after done", int'(busy), 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            check(nw == 2 && busy == 1'b0 && taken_vec == 8'(exp_vec), "R10",
                  "request during busy ignored", nw, 2);
            check(hnd_off == mem_word(ent), "R9", "result held", int'(hnd_off),
                  int'(mem_word(ent)));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && wr_en == 0 && rd_en == 0, "R11", "idle after reset",
              int'(busy), 0);

        run_case(1'b0, 3'b000, 1'b1, 8'hCD, 8'h21, 16'h1000, 16'h0200, 16'h8000, 1'b0); // R3 legacy
        run_case(1'b0, 3'b000, 1'b1, 8'h90, 8'h21, 16'h1000, 16'h0200, 16'h8000, 1'b0); // R1
        load_base(16'hFF80);
        run_case(1'b1, 3'b000, 1'b1, 8'hCD, 8'hFF, 16'h2222, 16'h0010, 16'h7000, 1'b0); // R2 wrap
        run_case(1'b0, 3'b000, 1'b1, 8'hCD, 8'h00, 16'h3333, 16'hFFFF, 16'h6000, 1'b0); // R6 wrap
        run_case(1'b0, 3'b110, 1'b0, 8'h00, 8'h00, 16'h4444, 16'h0400, 16'h5000, 1'b0); // R4
        run_case(1'b1, 3'b100, 1'b0, 8'h00, 8'h00, 16'h4444, 16'h0402, 16'h5000, 1'b0); // R4
        run_case(1'b0, 3'b111, 1'b0, 8'h00, 8'h00, 16'h4444, 16'h0404, 16'h5000, 1'b0); // R4
        run_case(1'b1, 3'b010, 1'b1, 8'hCD, 8'h80, 16'h5555, 16'h0600, 16'h4000, 1'b0); // R5
        run_case(1'b0, 3'b000, 1'b1, 8'hCD, 8'h13, 16'h6666, 16'h0700, 16'h3000, 1'b1); // R10

        // R11: reset clears the table-base register
        load_base(16'h1234);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        model_base = 16'h0;
        run_case(1'b1, 3'b000, 1'b1, 8'hCD, 8'h10, 16'h7777, 16'h0800, 16'h2000, 1'b0); // R11

        for (int k = 0; k < 40; k++) begin
            logic [2:0] fb;
            if (($urandom % 4) == 0) load_base(16'($urandom));
            fb = (($urandom % 3) == 0) ? 3'($urandom) : 3'b000;
            run_case(1'($urandom), fb, 1'($urandom % 4 != 0),
                     (($urandom % 5) == 0) ? 8'($urandom) : 8'hCD,
                     8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                     1'($urandom % 4 == 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule